// File: doc/BRIEF.md
# Multi-Channel Down-Counter Timer Unit

This block is a register-mapped timer unit built around two or three independent down-counting channels. It has one small request bus with a single-cycle request, a write flag, a word address and write data. Each read answers exactly one cycle later with a valid strobe. A shared run register holds one run bit per channel. An optional one-bit output-control register drives a pin. An address decoder sends every other access to a channel's own register window. Before the access reaches the channel, the decoder rebases the address to the start of that window.

Each channel has a reload constant, a live count and a control word. The control word holds a prescale select, an interrupt enable and a sticky underflow flag. A running channel steps its count down once per prescaler tick. When the count is already zero at a tick, the channel reloads the count from the constant and sets the flag. The build parameter `HAS_CH2` decides whether the third channel exists. `HAS_OCTL` decides whether the output-control register exists. Interrupts leave the block once per channel and once as an OR of all channels. An access to an offset the build does not define pulses a one-cycle error flag and does nothing else.

Top module: `tmr_unit`

## Requirements
- R1: Reset values. After reset, `rvalid`, `err`, `rdata`, `irq_ch`, `irq_any` and `out_ctl` are 0. The run register reads 0. Every reload constant and every count reads all ones. Every control word reads 0.
- R2: Address map and read timing. Channel windows begin at byte offsets 0x08, 0x14 and 0x20. Inside a window, word offset +0 is the reload constant, +4 is the count and +8 is the control word. Channel 2 also has a plain read/write holding word at 0x2C. A read returns its data with `rvalid` high in the cycle after the request. A write never raises `rvalid`.
- R3: Output control. When `HAS_OCTL` is set, offset 0x00 stores only bit 0 of the written data. That bit drives `out_ctl`, and a read of 0x00 returns it in bit 0 with all other bits zero.
- R4: Run register. Offset 0x04 stores the low 8 bits of the written data and reads them back unchanged. Bit n set makes channel n run, starting from the cycle after the write.
- R5: Stop and resume. While its run bit is clear, a channel's count and prescaler hold their values. Setting the bit again continues from the held count with no reload.
- R6: Counting and prescaling. The control word's bits [2:0] select the prescaler period: 4, 16, 64, 256 or 1024 cycles for values 0 to 4, and values 5 to 7 behave as 4. Each run cycle advances a 10-bit prescaler that starts at zero. A tick occurs on the last cycle of each period. On a tick, a non-zero count decrements. A zero count instead reloads from the constant and sets the underflow flag, control bit 8.
- R7: Control word. A write stores bits [2:0] and bit 5, the interrupt enable. The same write clears the flag if bit 8 is 0 and leaves the flag unchanged if bit 8 is 1. An underflow in the same cycle wins over the clear. A read returns bits [2:0], 5 and 8 with every other bit zero.
- R8: Interrupts. `irq_ch[n]` is high while channel n's flag and enable are both set. `irq_any` is the OR of all channel interrupts. An absent channel's bit is 0.
- R9: Undefined offsets. The undefined offsets are: any address not a multiple of 4, 0x00 without `HAS_OCTL`, anything at or above 0x30, and anything at or above 0x20 without `HAS_CH2`. An access to one of them pulses `err` in the following cycle. Such a read returns zero data, and such a write changes no state.
- R10: Missing third channel. Without `HAS_CH2`, a run-register write that has bit 2 set is rejected as a whole. `err` pulses and the run register keeps its old value.
- R11: Count write priority. A write to a channel's count in the same cycle as a tick loads the written value. The tick then neither decrements, nor reloads, nor sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request, one cycle per access |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | AW | Byte address of the access |
| wdata | input | DW | Write data |
| rvalid | output | 1 | Read data valid, one cycle after a read request |
| rdata | output | DW | Read data, zero for undefined offsets |
| err | output | 1 | One-cycle pulse after an access to an undefined offset |
| irq_ch | output | 3 | Per-channel interrupt lines |
| irq_any | output | 1 | OR of all channel interrupts |
| out_ctl | output | 1 | Stored output-control bit |

## Verification
The checker assumes that `req`, `we`, `addr` and `wdata` are stable around each rising edge and change only between edges. It also assumes that `req` stays low during reset, so that the first post-reset `$past` values are reset values. The bench drives every input on the falling edge and holds `req` low through reset. Its back-to-back count writes land on prescaler ticks through ordinary bus traffic, never by forcing internal state. Two instances share the bus, one with all options and one with neither option, so that the same access is both legal and illegal at once.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  // Decoder targets
  typedef enum logic [1:0] {
    TGT_OCTL  = 2'd0,
    TGT_START = 2'd1,
    TGT_CHAN  = 2'd2,
    TGT_BAD   = 2'd3
  } tgt_e;

  localparam int CH_MAX     = 3;   // largest channel count
  localparam int START_W    = 8;   // stored width of the run register
  localparam int PRE_W      = 10;  // prescaler width (largest period 1024)

  // Byte offsets in the unit's address space
  localparam int OFS_OCTL   = 0;
  localparam int OFS_START  = 4;
  localparam int WIN_BASE   = 8;   // channel 0 window start
  localparam int WIN_STRIDE = 12;  // three words per channel window
  localparam int WIN2_WORDS = 4;   // channel 2 carries an extra holding word

  // Control word bit positions
  localparam int CTL_IE_BIT   = 5;
  localparam int CTL_FLAG_BIT = 8;

  // Word indices inside a channel window
  localparam logic [1:0] W_RELOAD = 2'd0;
  localparam logic [1:0] W_COUNT  = 2'd1;
  localparam logic [1:0] W_CTRL   = 2'd2;
  localparam logic [1:0] W_HOLD   = 2'd3;

  // Low-bit mask whose all-ones state marks the last cycle of a prescale period.
  function automatic logic [PRE_W-1:0] presc_mask(input logic [2:0] sel);
    int k;
    k = (sel > 3'd4) ? 0 : int'(sel);
    return PRE_W'((1 << (2 * k + 2)) - 1);
  endfunction

  // Start of a channel's window.
  function automatic int win_start(input int ch);
    return WIN_BASE + ch * WIN_STRIDE;
  endfunction

endpackage

// File: rtl/tmr_decode.sv
module tmr_decode
  import tmr_pkg::*;
#(
  parameter int AW       = 6,
  parameter bit HAS_CH2  = 1'b1,
  parameter bit HAS_OCTL = 1'b1
) (
  input  logic [AW-1:0] addr,
  output tgt_e          tgt,
  output logic [1:0]    chan,
  output logic [1:0]    word
);

  localparam int CH2_END = win_start(2) + 4 * WIN2_WORDS;

  always_comb begin
    int a;
    a    = int'(addr);
    tgt  = TGT_BAD;
    chan = 2'd0;
    word = 2'd0;
    if (addr[1:0] == 2'b00) begin
      if (a == OFS_OCTL) begin
        if (HAS_OCTL) tgt = TGT_OCTL;
      end else if (a == OFS_START) begin
        tgt = TGT_START;
      end else if (a < win_start(1)) begin
        tgt  = TGT_CHAN;
        chan = 2'd0;
        word = 2'((a - win_start(0)) >> 2);
      end else if (a < win_start(2)) begin
        tgt  = TGT_CHAN;
        chan = 2'd1;
        word = 2'((a - win_start(1)) >> 2);
      end else if (HAS_CH2 && (a < CH2_END)) begin
        tgt  = TGT_CHAN;
        chan = 2'd2;
        word = 2'((a - win_start(2)) >> 2);
      end
    end
  end

endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int CW       = 32,
  parameter int DW       = 32,
  parameter bit HAS_HOLD = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          acc_sel,
  input  logic          acc_wr,
  input  logic [1:0]    acc_word,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rd_val,
  output logic          irq,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] rel_o,
  output logic          cnt_wr_o,
  output logic          ctl_wr_o,
  output logic          unf_o
);

  logic [CW-1:0]    cnt_q, rel_q;
  logic [2:0]       sel_q;
  logic             ie_q, flag_q;
  logic [PRE_W-1:0] pre_q;
  logic [DW-1:0]    hold_q;
  logic             wr_rel, wr_cnt, wr_ctl, tick, unf;
  logic [PRE_W-1:0] pmask;

  assign wr_rel = acc_sel && acc_wr && (acc_word == W_RELOAD);
  assign wr_cnt = acc_sel && acc_wr && (acc_word == W_COUNT);
  assign wr_ctl = acc_sel && acc_wr && (acc_word == W_CTRL);

  assign pmask = presc_mask(sel_q);
  assign tick  = run && ((pre_q & pmask) == pmask);
  assign unf   = tick && !wr_cnt && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '1;
      rel_q  <= '1;
      sel_q  <= 3'd0;
      ie_q   <= 1'b0;
      flag_q <= 1'b0;
      pre_q  <= '0;
    end else begin
      if (run) pre_q <= pre_q + 1'b1;
      if (wr_rel) rel_q <= wdata[CW-1:0];
      if (wr_cnt)      cnt_q <= wdata[CW-1:0];
      else if (unf)    cnt_q <= rel_q;
      else if (tick)   cnt_q <= cnt_q - 1'b1;
      if (wr_ctl) begin
        sel_q <= wdata[2:0];
        ie_q  <= wdata[CTL_IE_BIT];
      end
      if (unf)                                  flag_q <= 1'b1;
      else if (wr_ctl && !wdata[CTL_FLAG_BIT])  flag_q <= 1'b0;
    end
  end

  generate
    if (HAS_HOLD) begin : g_hold
      logic wr_hold;
      assign wr_hold = acc_sel && acc_wr && (acc_word == W_HOLD);
      always_ff @(posedge clk) begin
        if (!rst_n)       hold_q <= '0;
        else if (wr_hold) hold_q <= wdata;
      end
    end else begin : g_nohold
      assign hold_q = '0;
    end
  endgenerate

  always_comb begin
    rd_val = '0;
    case (acc_word)
      W_RELOAD: rd_val = DW'(rel_q);
      W_COUNT:  rd_val = DW'(cnt_q);
      W_CTRL: begin
        rd_val[2:0]          = sel_q;
        rd_val[CTL_IE_BIT]   = ie_q;
        rd_val[CTL_FLAG_BIT] = flag_q;
      end
      default:  rd_val = hold_q;
    endcase
  end

  assign irq      = flag_q && ie_q;
  assign cnt_o    = cnt_q;
  assign rel_o    = rel_q;
  assign cnt_wr_o = wr_cnt;
  assign ctl_wr_o = wr_ctl;
  assign unf_o    = unf;

endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
#(
  parameter int AW       = 6,
  parameter int DW       = 32,
  parameter int CW       = 32,
  parameter bit HAS_CH2  = 1'b1,
  parameter bit HAS_OCTL = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          rvalid,
  output logic [DW-1:0] rdata,
  output logic          err,
  output logic [2:0]    irq_ch,
  output logic          irq_any,
  output logic          out_ctl
);

  localparam int NCH = HAS_CH2 ? 3 : 2;

  tgt_e                       tgt;
  logic [1:0]                 chan, word;
  logic                       start_rej, bad, wr_ok;
  logic [START_W-1:0]         start_q;
  logic                       octl_q;
  logic [CH_MAX-1:0]          run_vec, cnt_wr_vec, ctl_wr_vec, unf_vec, sel_vec;
  logic [CH_MAX-1:0][CW-1:0]  cnt_all, rel_all;
  logic [DW-1:0]              ch_rd [CH_MAX];
  logic [DW-1:0]              rd_mux;

  tmr_decode #(.AW(AW), .HAS_CH2(HAS_CH2), .HAS_OCTL(HAS_OCTL)) u_dec (
    .addr (addr),
    .tgt  (tgt),
    .chan (chan),
    .word (word)
  );

  // A run-register write naming the missing channel is rejected as a whole.
  assign start_rej = req && we && (tgt == TGT_START) && !HAS_CH2 && wdata[2];
  assign bad       = (tgt == TGT_BAD) || start_rej;
  assign wr_ok     = req && we && !bad;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= '0;
      octl_q  <= 1'b0;
    end else begin
      if (wr_ok && (tgt == TGT_START)) start_q <= wdata[START_W-1:0];
      if (wr_ok && (tgt == TGT_OCTL))  octl_q  <= wdata[0];
    end
  end

  genvar c;
  generate
    for (c = 0; c < CH_MAX; c++) begin : g_ch
      if (c < NCH) begin : g_on
        assign run_vec[c] = start_q[c];
        assign sel_vec[c] = req && (tgt == TGT_CHAN) && (chan == 2'(c));
        tmr_chan #(.CW(CW), .DW(DW), .HAS_HOLD(c == 2)) u_chan (
          .clk      (clk),
          .rst_n    (rst_n),
          .run      (run_vec[c]),
          .acc_sel  (sel_vec[c]),
          .acc_wr   (we),
          .acc_word (word),
          .wdata    (wdata),
          .rd_val   (ch_rd[c]),
          .irq      (irq_ch[c]),
          .cnt_o    (cnt_all[c]),
          .rel_o    (rel_all[c]),
          .cnt_wr_o (cnt_wr_vec[c]),
          .ctl_wr_o (ctl_wr_vec[c]),
          .unf_o    (unf_vec[c])
        );
      end else begin : g_off
        assign run_vec[c]    = 1'b0;
        assign sel_vec[c]    = 1'b0;
        assign ch_rd[c]      = '0;
        assign irq_ch[c]     = 1'b0;
        assign cnt_all[c]    = '0;
        assign rel_all[c]    = '0;
        assign cnt_wr_vec[c] = 1'b0;
        assign ctl_wr_vec[c] = 1'b0;
        assign unf_vec[c]    = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    rd_mux = '0;
    case (tgt)
      TGT_OCTL:  rd_mux[0] = octl_q;
      TGT_START: rd_mux    = DW'(start_q);
      TGT_CHAN:  rd_mux    = ch_rd[chan];
      default:   rd_mux    = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      err    <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= req && !we;
      err    <= req && bad;
      rdata  <= (req && !we && !bad) ? rd_mux : '0;
    end
  end

  assign irq_any = |irq_ch;
  assign out_ctl = octl_q;

endmodule

// File: rtl/tmr_unit_chk.sv
module tmr_unit_chk
  import tmr_pkg::*;
#(
  parameter int DW = 32,
  parameter int CW = 32
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      req,
  input logic                      we,
  input logic                      rvalid,
  input logic [DW-1:0]             rdata,
  input logic                      err,
  input logic [2:0]                irq_ch,
  input logic [CH_MAX-1:0]         run_vec,
  input logic [CH_MAX-1:0]         cnt_wr_vec,
  input logic [CH_MAX-1:0]         ctl_wr_vec,
  input logic [CH_MAX-1:0]         unf_vec,
  input logic [CH_MAX-1:0][CW-1:0] cnt_all,
  input logic [CH_MAX-1:0][CW-1:0] rel_all,
  input logic [START_W-1:0]        start_q,
  input logic                      start_rej
);

  AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !we) |=> rvalid); // R2

  AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (req && we) |=> !rvalid); // R2

  AST_BAD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid && err) |-> (rdata == '0)); // R9

  AST_START_REJECT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    start_rej |=> $stable(start_q)); // R10

  genvar c;
  generate
    for (c = 0; c < CH_MAX; c++) begin : g_a
      AST_HALT_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_vec[c] && !cnt_wr_vec[c]) |=> $stable(cnt_all[c])); // R5

      AST_UNDERFLOW_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
        unf_vec[c] |=> (cnt_all[c] == $past(rel_all[c]))); // R6

      AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_ch[c]) |-> $past(unf_vec[c] || ctl_wr_vec[c])); // R8
    end
  endgenerate

endmodule

bind tmr_unit tmr_unit_chk #(.DW(DW), .CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req        (req),
  .we         (we),
  .rvalid     (rvalid),
  .rdata      (rdata),
  .err        (err),
  .irq_ch     (irq_ch),
  .run_vec    (run_vec),
  .cnt_wr_vec (cnt_wr_vec),
  .ctl_wr_vec (ctl_wr_vec),
  .unf_vec    (unf_vec),
  .cnt_all    (cnt_all),
  .rel_all    (rel_all),
  .start_q    (start_q),
  .start_rej  (start_rej)
);

// File: tb/tb_tmr_unit.sv
module tb_tmr_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;

  logic        rv_a, er_a, any_a, oc_a;
  logic [31:0] rd_a;
  logic [2:0]  iq_a;
  logic        rv_b, er_b, any_b, oc_b;
  logic [31:0] rd_b;
  logic [2:0]  iq_b;

  always #2 clk = ~clk;  // 250 MHz

  tmr_unit #(.HAS_CH2(1'b1), .HAS_OCTL(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .rvalid(rv_a), .rdata(rd_a), .err(er_a), .irq_ch(iq_a), .irq_any(any_a), .out_ctl(oc_a));

  tmr_unit #(.HAS_CH2(1'b0), .HAS_OCTL(1'b0)) dut_b (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .rvalid(rv_b), .rdata(rd_b), .err(er_b), .irq_ch(iq_b), .irq_any(any_b), .out_ctl(oc_b));

  int    n_chk = 0;
  int    n_fail = 0;
  int    cycles = 0;
  string cur_req = "R1";

  // ---------------- behavioural reference model ----------------
  bit          has2 [2] = '{1'b1, 1'b0};
  bit          hasoc[2] = '{1'b1, 1'b0};
  logic [31:0] m_rel [2][3];
  logic [31:0] m_cnt [2][3];
  int          m_sel [2][3];
  int          m_pre [2][3];
  bit          m_ie  [2][3];
  bit          m_flag[2][3];
  logic [31:0] m_start[2];
  logic [31:0] m_hold [2];
  bit          m_oc   [2];
  bit          m_rv   [2];
  bit          m_err  [2];
  logic [31:0] m_rd   [2];

  // -1 undefined, 0 output control, 1 run register, 2 channel
  function automatic int classify(int m, int a, logic [31:0] d, bit w,
                                  output int ch, output int wd);
    ch = 0; wd = 0;
    if (a % 4 != 0) return -1;
    if (a == 0) return hasoc[m] ? 0 : -1;
    if (a == 4) return (w && !has2[m] && d[2]) ? -1 : 1;
    if (a < 20) begin ch = 0; wd = (a - 8) / 4;  return 2; end
    if (a < 32) begin ch = 1; wd = (a - 20) / 4; return 2; end
    if (a < 48 && has2[m]) begin ch = 2; wd = (a - 32) / 4; return 2; end
    return -1;
  endfunction

  function automatic int period(int sel);
    int p;
    p = 4;
    if (sel <= 4) for (int i = 0; i < sel; i++) p = p * 4;
    return p;
  endfunction

  function automatic bit chan_on(int m, int i);
    return (i < 2) || has2[m];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int m = 0; m < 2; m++) begin
        for (int i = 0; i < 3; i++) begin
          m_rel[m][i] = '1; m_cnt[m][i] = '1; m_sel[m][i] = 0;
          m_pre[m][i] = 0;  m_ie[m][i] = 0;   m_flag[m][i] = 0;
        end
        m_start[m] = '0; m_hold[m] = '0; m_oc[m] = 0;
        m_rv[m] = 0; m_err[m] = 0; m_rd[m] = '0;
      end
    end else begin
      for (int m = 0; m < 2; m++) begin
        int k, ch, wd;
        bit tk[3];
        bit run[3];
        bit wr;
        logic [31:0] rv;
        k = classify(m, int'(addr), wdata, we, ch, wd);
        for (int i = 0; i < 3; i++) begin
          run[i] = m_start[m][i] && chan_on(m, i);
          tk[i]  = run[i] && ((m_pre[m][i] % period(m_sel[m][i])) == period(m_sel[m][i]) - 1);
        end
        rv = '0;
        if (k == 0) rv = {31'd0, m_oc[m]};
        else if (k == 1) rv = m_start[m];
        else if (k == 2) begin
          if (wd == 0) rv = m_rel[m][ch];
          else if (wd == 1) rv = m_cnt[m][ch];
          else if (wd == 2) rv = 32'(m_sel[m][ch]) | (32'(m_ie[m][ch]) << 5) | (32'(m_flag[m][ch]) << 8);
          else rv = m_hold[m];
        end
        m_rv[m]  = req && !we;
        m_err[m] = req && (k < 0);
        m_rd[m]  = (req && !we && k >= 0) ? rv : '0;
        wr = req && we && (k >= 0);
        for (int i = 0; i < 3; i++) begin
          bit uf;
          bit here;
          uf = 0;
          here = wr && (k == 2) && (ch == i);
          if (run[i]) m_pre[m][i] = (m_pre[m][i] + 1) % 1024;
          if (here && wd == 1) m_cnt[m][i] = wdata;
          else if (tk[i]) begin
            if (m_cnt[m][i] == 0) begin m_cnt[m][i] = m_rel[m][i]; uf = 1; end
            else m_cnt[m][i] = m_cnt[m][i] - 1;
          end
          if (here && wd == 2) begin
            m_sel[m][i] = int'(wdata[2:0]);
            m_ie[m][i]  = wdata[5];
            if (!wdata[8]) m_flag[m][i] = 0;
          end
          if (uf) m_flag[m][i] = 1;
          if (here && wd == 0) m_rel[m][i] = wdata;
          if (here && wd == 3) m_hold[m] = wdata;
        end
        if (wr && k == 1) m_start[m] = wdata & 32'hFF;
        if (wr && k == 0) m_oc[m] = wdata[0];
      end
    end
  end

  task automatic check(string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_irq(int m);
    logic [2:0] v;
    for (int i = 0; i < 3; i++) v[i] = chan_on(m, i) && m_flag[m][i] && m_ie[m][i];
    return v;
  endfunction

  // Compare both instances against the model every cycle, away from the edge.
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      check("A rvalid",  32'(rv_a),  32'(m_rv[0]));
      check("A rdata",   rd_a,       m_rd[0]);
      check("A err",     32'(er_a),  32'(m_err[0]));
      check("A irq_ch",  32'(iq_a),  32'(exp_irq(0)));
      check("A irq_any", 32'(any_a), 32'(|exp_irq(0)));
      check("A out_ctl", 32'(oc_a),  32'(m_oc[0]));
      check("B rvalid",  32'(rv_b),  32'(m_rv[1]));
      check("B rdata",   rd_b,       m_rd[1]);
      check("B err",     32'(er_b),  32'(m_err[1]));
      check("B irq_ch",  32'(iq_b),  32'(exp_irq(1)));
      check("B irq_any", 32'(any_b), 32'(|exp_irq(1)));
      check("B out_ctl", 32'(oc_b),  32'(m_oc[1]));
    end
    if (cycles > 150000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic wr(int a, logic [31:0] d);
    req = 1; we = 1; addr = 6'(a); wdata = d;
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic rd(int a);
    req = 1; we = 0; addr = 6'(a); wdata = '0;
    @(negedge clk);
    req = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    idle(2);

    cur_req = "R1";  // reset values
    rd(4); rd(12); rd(8); rd(16); rd(36); idle(1);

    cur_req = "R3";  // output control, single stored bit
    wr(0, 32'hFFFF_FFFF); rd(0); idle(1);
    wr(0, 32'h0000_0002); rd(0); idle(1);

    cur_req = "R2";  // window decode and rebasing
    wr(8, 32'd5); wr(20, 32'd7); wr(32, 32'd9); wr(44, 32'hABCD_1234);
    rd(8); rd(20); rd(32); rd(44); idle(1);

    cur_req = "R7";  // control word stored bits, flag write-1 keeps
    wr(16, 32'hFFFF_FFF8); rd(16);
    wr(16, 32'h0000_0120); rd(16); idle(1);

    cur_req = "R6";  // ch0 counts with period 4, underflows and reloads
    wr(12, 32'd3); wr(4, 32'h01); idle(40); rd(12); rd(16);

    cur_req = "R8";  // interrupt then clear with bit 8 = 0
    idle(4); wr(16, 32'h0000_0020); rd(16); idle(2);

    cur_req = "R5";  // stop holds count, resume continues
    wr(4, 32'h00); rd(12); idle(30); rd(12); wr(4, 32'h01); idle(9); rd(12);

    cur_req = "R11"; // count writes coinciding with ticks
    wr(12, 32'd0); wr(12, 32'd0); wr(12, 32'd0); wr(12, 32'd0); idle(6); rd(12);

    cur_req = "R4";  // run register readback, channel 1 with period 16
    wr(28, 32'h0000_0021); wr(24, 32'd2);
    wr(4, 32'h0000_01A3); rd(4); idle(120); rd(24); rd(28);

    cur_req = "R9";  // undefined offsets
    rd(48); rd(6); wr(60, 32'h1); rd(33); rd(32); wr(0, 32'h1); rd(0); idle(2);

    cur_req = "R10"; // run bit 2 rejected where channel 2 is absent
    wr(40, 32'h0000_0025); wr(36, 32'd2);
    wr(4, 32'h0000_0004); rd(4); idle(3200); rd(36); rd(40);
    wr(4, 32'h0000_0007); rd(4); idle(1);

    cur_req = "R6";  // prescale select 1..4 on ch0
    for (int s = 1; s <= 4; s++) begin
      wr(16, 32'(s) | 32'h20); wr(8, 32'd1); wr(12, 32'd1); wr(4, 32'h1);
      idle(3 * period(s) + 8); rd(12); rd(16);
    end
    wr(4, 32'h0); idle(3);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule